// File: doc/BRIEF.md
# Double-Buffered Two-Channel Converter Front End

This block is the digital side of a two-channel 8-bit voltage converter. A host writes bytes over a parallel bus qualified by an active-low chip select and an active-low write strobe, with a channel line picking the target. Every channel holds two stages: a staging register that takes the byte when the write ends, and an output register whose value feeds the analog side as an unsigned code (0 gives ground, 0x80 gives the reference level, 255 gives 255/256 of twice the reference).

The level of the active-low load line when a write ends chooses the update policy for that write. A low level moves the byte straight into the output register of the written channel. A high level leaves both output registers alone until the load line next falls, and then both channels change together. An active-low clear zeroes both outputs. An active-low power-down raises a flag for the analog side and leaves every register as it was. All pins are asynchronous to the block and are brought onto a fast system clock through synchronisers.

Top module: `dacfe_top`

## Requirements
- R1: A write is the interval in which `cs_n` and `wr_n` are both low. The byte on `bus_d` and the levels of `sel_a` and `load_n` are taken from the last system-clock sample inside that interval. Bus changes after either strobe has risen have no effect, whichever strobe rises first.
- R2: `sel_a` high routes a write to channel A (`code_a`), low to channel B (`code_b`). A write never changes the other channel's output.
- R3: If `load_n` was low at the end of a write, the written channel's output takes the written byte.
- R4: If `load_n` was high at the end of a write, neither output changes because of that write.
- R5: A falling edge of `load_n` copies both staging registers into both output registers together.
- R6: While `clear_n` is low, both outputs are forced to zero, and this wins over a coincident load edge or automatic update. A write made during clear still reaches the staging register and can be moved to the output by a later load edge.
- R7: After reset both staging registers are zero and both outputs read zero, `pdown_o` is 0 and both update pulses are 0, and this holds until the first write.
- R8: `pdown_o` is high while `pdown_n` is low and low otherwise. Power-down changes no staging or output register.
- R9: `upd_a` / `upd_b` is high for exactly one cycle, the cycle in which that channel's new code first appears. It stays low when a load or write leaves the code unchanged.
- R10: A pin change is seen after the two synchroniser stages. The new code appears after the 4th rising clock edge following the pin edge that ends a write or pulls `load_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than any pin activity |
| rst_n | input | 1 | Synchronous active-low reset (power-on state) |
| bus_d | input | 8 | Parallel data byte, straight binary |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| sel_a | input | 1 | Channel select, 1 = A, 0 = B |
| load_n | input | 1 | Active-low load line, level and falling edge used |
| clear_n | input | 1 | Active-low clear of both outputs |
| pdown_n | input | 1 | Active-low power-down request |
| code_a | output | 8 | Output register of channel A |
| code_b | output | 8 | Output register of channel B |
| pdown_o | output | 1 | Power-down flag to the analog side |
| upd_a | output | 1 | One-cycle pulse when code_a changes |
| upd_b | output | 1 | One-cycle pulse when code_b changes |

## Verification
Random sequences mix automatic and deferred writes to both channels, standalone load pulses, clear windows with writes inside them, and power-down windows. Each step is compared against a bench model of the four registers. Write endings alternate between the chip select rising first and the write strobe rising first, and the bus is scrambled after the end, which separates a correct end-of-write capture from a late one. Writes of the value already held, and load edges that copy equal values, separate a real change pulse from a pulse on every event. Directed cases cover the exact output latency, a load edge that lands together with clear, and the all-zero state after reset.

// File: rtl/dacfe_pkg.sv
// Shared types for the converter front end.
package dacfe_pkg;

    // Completed-write event handed from the edge logic to the channels.
    typedef struct packed {
        logic valid;     // one-cycle strobe: a write just ended
        logic sel_a;     // 1 = channel A, 0 = channel B
        logic auto_upd;  // load line was low at the end of the write
    } wr_evt_t;

endpackage

// File: rtl/dacfe_pin_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes each pin is stable long enough for the system clock to see it;
// bits of the bundle are not kept coherent with each other.
module dacfe_pin_sync #(
    parameter int unsigned         W       = 8,
    parameter int unsigned         STAGES  = 2,
    parameter logic [W-1:0]        RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);

    logic [W-1:0] stg [STAGES];

    // Shift the pin values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= pin_i;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign pin_o = stg[STAGES-1];

endmodule

// File: rtl/dacfe_event_gen.sv
// Turns synchronised strobes into one-cycle events.
// A write ends on the first cycle where cs_n and wr_n are no longer both
// low; bus, select and load level are taken from the last cycle inside the
// write. A load event is a high-to-low step of the synchronised load line.
// Events are registered, so they appear one cycle after the edge is seen.
module dacfe_event_gen
    import dacfe_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              load_n,
    input  logic              sel_a,
    input  logic [DATA_W-1:0] bus_d,
    output wr_evt_t           wr_evt,
    output logic [DATA_W-1:0] wr_data,
    output logic              ld_evt
);

    logic              act_now;
    logic              act_q;
    logic              sel_q;
    logic              ldlow_q;
    logic [DATA_W-1:0] data_q;
    logic              load_prev;

    assign act_now = !cs_n && !wr_n;

    // Remember activity and the bus seen while the write is still open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            sel_q   <= 1'b0;
            ldlow_q <= 1'b0;
            data_q  <= '0;
        end else begin
            act_q <= act_now;
            if (act_now) begin
                sel_q   <= sel_a;
                ldlow_q <= !load_n;
                data_q  <= bus_d;
            end
        end
    end

    // Emit the end-of-write event with the captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_evt  <= '0;
            wr_data <= '0;
        end else begin
            wr_evt.valid    <= act_q && !act_now;
            wr_evt.sel_a    <= sel_q;
            wr_evt.auto_upd <= ldlow_q;
            wr_data         <= data_q;
        end
    end

    // Detect the falling edge of the load line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_prev <= 1'b1;
            ld_evt    <= 1'b0;
        end else begin
            load_prev <= load_n;
            ld_evt    <= load_prev && !load_n;
        end
    end

endmodule

// File: rtl/dacfe_channel.sv
// One converter channel: staging register followed by output register.
// Assumes events are one-cycle pulses. Clear dominates every update of the
// output register but never blocks a write into the staging register.
module dacfe_channel
    import dacfe_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter bit          IS_A   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_evt_t           wr_evt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_evt,
    input  logic              clr,
    output logic [DATA_W-1:0] code,
    output logic              upd
);

    logic              hit;
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] stage_n;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] out_n;

    assign hit = wr_evt.valid && (wr_evt.sel_a == IS_A);

    // Next staging value: take the byte on a write to this channel.
    always_comb begin
        stage_n = stage_q;
        if (hit) stage_n = wr_data;
    end

    // Next output value: clear, then automatic update, then load edge.
    always_comb begin
        out_n = out_q;
        if (clr)                        out_n = '0;
        else if (hit && wr_evt.auto_upd) out_n = wr_data;
        else if (ld_evt)                out_n = stage_q;
    end

    // Hold both registers and flag a change of the output code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            out_q   <= '0;
            upd     <= 1'b0;
        end else begin
            stage_q <= stage_n;
            out_q   <= out_n;
            upd     <= (out_n != out_q);
        end
    end

    assign code = out_q;

endmodule

// File: rtl/dacfe_top.sv
// Two-channel double-buffered converter register front end.
// All pins are asynchronous and pass through SYNC_STAGES flops; strobes must
// stay in each level for more than SYNC_STAGES system-clock cycles.
// Reset gives the power-on state: every register zero, outputs at zero.
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_d,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              sel_a,
    input  logic              load_n,
    input  logic              clear_n,
    input  logic              pdown_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              pdown_o,
    output logic              upd_a,
    output logic              upd_b
);

    localparam int unsigned NCH    = 2;
    localparam int unsigned PIN_W  = DATA_W + 6;
    localparam logic [PIN_W-1:0] PIN_RST = {5'b11111, 1'b0, {DATA_W{1'b0}}};

    logic [PIN_W-1:0]  pins_raw;
    logic [PIN_W-1:0]  pins_s;
    logic              cs_s, wr_s, load_s, clrn_s, pdn_s, sel_s;
    logic [DATA_W-1:0] bus_s;
    logic              clr_s;
    wr_evt_t           wr_evt;
    logic [DATA_W-1:0] wr_data;
    logic              ld_evt;
    logic [DATA_W-1:0] codes [NCH];
    logic [NCH-1:0]    upds;

    assign pins_raw = {cs_n, wr_n, load_n, clear_n, pdown_n, sel_a, bus_d};

    dacfe_pin_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pins_raw),
        .pin_o (pins_s)
    );

    assign {cs_s, wr_s, load_s, clrn_s, pdn_s, sel_s, bus_s} = pins_s;
    assign clr_s = !clrn_s;

    dacfe_event_gen #(
        .DATA_W (DATA_W)
    ) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_s),
        .wr_n    (wr_s),
        .load_n  (load_s),
        .sel_a   (sel_s),
        .bus_d   (bus_s),
        .wr_evt  (wr_evt),
        .wr_data (wr_data),
        .ld_evt  (ld_evt)
    );

    // Channel 0 is A (selected by sel_a high), channel 1 is B.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dacfe_channel #(
            .DATA_W (DATA_W),
            .IS_A   (ch == 0)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_evt  (wr_evt),
            .wr_data (wr_data),
            .ld_evt  (ld_evt),
            .clr     (clr_s),
            .code    (codes[ch]),
            .upd     (upds[ch])
        );
    end

    // Register the power-down flag from the synchronised pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pdown_o <= 1'b0;
        else        pdown_o <= !pdn_s;
    end

    assign code_a = codes[0];
    assign code_b = codes[1];
    assign upd_a  = upds[0];
    assign upd_b  = upds[1];

endmodule

// File: rtl/dacfe_checks.sv
// Property checker for dacfe_top, attached by bind below.
module dacfe_checks
    import dacfe_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              pd_req,
    input wr_evt_t           wr_evt,
    input logic [DATA_W-1:0] wr_data,
    input logic              ld_evt,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic              pdown_o,
    input logic              upd_a,
    input logic              upd_b
);

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (code_a == '0 && code_b == '0));

    assert_auto_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt.valid && wr_evt.sel_a && wr_evt.auto_upd && !clr) |=> code_a == $past(wr_data));

    assert_auto_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt.valid && !wr_evt.sel_a && wr_evt.auto_upd && !clr) |=> code_b == $past(wr_data));

    assert_other_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt.valid && wr_evt.sel_a && !ld_evt && !clr) |=> $stable(code_b));

    assert_defer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt.valid && !wr_evt.auto_upd && !ld_evt && !clr) |=> ($stable(code_a) && $stable(code_b)));

    assert_pd_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> pdown_o);

    assert_upd_change_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_a |-> code_a != $past(code_a));

    assert_upd_quiet_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_b |-> $stable(code_b));

endmodule

bind dacfe_top dacfe_checks #(.DATA_W(DATA_W)) u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_s),
    .pd_req  (!pdn_s),
    .wr_evt  (wr_evt),
    .wr_data (wr_data),
    .ld_evt  (ld_evt),
    .code_a  (code_a),
    .code_b  (code_b),
    .pdown_o (pdown_o),
    .upd_a   (upd_a),
    .upd_b   (upd_b)
);

// File: tb/test_dacfe_top.sv
`timescale 1ns/1ps
module test_dacfe_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_d = 8'h00;
    logic       cs_n = 1'b1, wr_n = 1'b1, sel_a = 1'b0;
    logic       load_n = 1'b1, clear_n = 1'b1, pdown_n = 1'b1;
    logic [7:0] code_a, code_b;
    logic       pdown_o, upd_a, upd_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [7:0] m_stage [2];
    logic [7:0] m_out [2];
    bit         m_clr = 1'b0;
    int         exp_pulse [2];
    int         got_a = 0, got_b = 0;

    always #2 clk = ~clk;

    dacfe_top i_dacfe_top (
        .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .cs_n(cs_n), .wr_n(wr_n),
        .sel_a(sel_a), .load_n(load_n), .clear_n(clear_n), .pdown_n(pdown_n),
        .code_a(code_a), .code_b(code_b), .pdown_o(pdown_o),
        .upd_a(upd_a), .upd_b(upd_b)
    );

    // count update pulses away from the active edge
    always @(negedge clk) begin
        if (upd_a) got_a++;
        if (upd_b) got_b++;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void set_out(int ch, logic [7:0] v);
        if (m_out[ch] != v) exp_pulse[ch]++;
        m_out[ch] = v;
    endfunction

    function automatic void model_load();
        for (int c = 0; c < 2; c++) set_out(c, m_clr ? 8'h00 : m_stage[c]);
    endfunction

    function automatic void model_write(bit to_a, logic [7:0] v, bit auto_upd);
        int c = to_a ? 0 : 1;
        m_stage[c] = v;
        if (m_clr) set_out(c, 8'h00);
        else if (auto_upd) set_out(c, v);
    endfunction

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic compare(string tag);
        check({tag, " R3 R4 R5 code_a"}, code_a, m_out[0]);
        check({tag, " R2 code_b"}, code_b, m_out[1]);
        check({tag, " R9 pulses_a"}, got_a, exp_pulse[0]);
        check({tag, " R9 pulses_b"}, got_b, exp_pulse[1]);
    endtask

    // R1: write with selectable ending order, bus scrambled after the end
    task automatic do_write(bit to_a, logic [7:0] v, bit ld_low, bit wr_first);
        @(negedge clk);
        sel_a = to_a; bus_d = v;
        if (ld_low && load_n) begin load_n = 1'b0; model_load(); end
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        if (wr_first) wr_n = 1'b1; else cs_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_d = ~v; sel_a = ~to_a;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(to_a, v, ld_low);
        repeat (3) @(negedge clk);
        load_n = 1'b1;
        settle();
    endtask

    task automatic load_pulse();
        @(negedge clk); load_n = 1'b0; model_load();
        repeat (5) @(negedge clk); load_n = 1'b1;
        settle();
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd1977);
        m_stage[0] = 0; m_stage[1] = 0; m_out[0] = 0; m_out[1] = 0;
        exp_pulse[0] = 0; exp_pulse[1] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R7 reset state
        check("R7 code_a reset", code_a, 0);
        check("R7 code_b reset", code_b, 0);
        check("R7 pdown_o reset", pdown_o, 0);
        check("R7 no pulses", got_a + got_b, 0);
        load_pulse();
        compare("R7 load before first write");

        // R10 exact latency of a load edge
        do_write(1'b1, 8'h5A, 1'b0, 1'b1);
        compare("deferred A");
        @(negedge clk); load_n = 1'b0; model_load();
        repeat (3) @(negedge clk);
        check("R10 code_a before 4th edge", code_a, 8'h00);
        @(negedge clk);
        check("R10 code_a after 4th edge", code_a, 8'h5A);
        load_n = 1'b1; settle();
        compare("R10 after load");

        // R6 clear coincident with load edge, write during clear
        do_write(1'b0, 8'hC3, 1'b0, 1'b0);
        @(negedge clk); clear_n = 1'b0; load_n = 1'b0; m_clr = 1'b1;
        set_out(0, 8'h00); set_out(1, 8'h00);
        repeat (4) @(negedge clk); load_n = 1'b1;
        settle();
        compare("R6 clear beats load");
        do_write(1'b1, 8'h77, 1'b1, 1'b1);
        compare("R6 write during clear");
        @(negedge clk); clear_n = 1'b1; m_clr = 1'b0; settle();
        load_pulse();
        compare("R6 staged byte survives clear");

        // R8 power-down
        @(negedge clk); pdown_n = 1'b0; settle();
        check("R8 pdown_o high", pdown_o, 1);
        compare("R8 during power-down");
        @(negedge clk); pdown_n = 1'b1; settle();
        check("R8 pdown_o low", pdown_o, 0);
        load_pulse();
        compare("R8 after power-down");

        // random mix
        for (int n = 0; n < 150; n++) begin
            int op = $urandom_range(0, 9);
            if (op < 6) begin
                logic [7:0] v = ($urandom_range(0, 3) == 0) ? m_out[op & 1] : 8'($urandom);
                do_write(op[0], v, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
                compare("R1 random write");
            end else if (op < 8) begin
                load_pulse();
                compare("R5 random load");
            end else if (op == 8) begin
                @(negedge clk); clear_n = 1'b0; m_clr = 1'b1;
                set_out(0, 8'h00); set_out(1, 8'h00);
                settle();
                if ($urandom_range(0, 1) == 1)
                    do_write($urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 1) == 1, 1'b1);
                @(negedge clk); clear_n = 1'b1; m_clr = 1'b0; settle();
                compare("R6 random clear");
            end else begin
                @(negedge clk); pdown_n = 1'b0; settle();
                check("R8 random pdown_o", pdown_o, 1);
                compare("R8 random power-down");
                @(negedge clk); pdown_n = 1'b1; settle();
                check("R8 random pdown_o release", pdown_o, 0);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule